// File: doc/BRIEF.md
# Stream Frame Descriptor Update Sequencer

This block sits on the device-to-host streaming receive path. It takes stream beats that carry start-of-frame and end-of-frame markers plus a valid byte count, and spends them against receive descriptors that arrive one at a time, already fetched, on a valid/ready port. It counts the bytes placed into the descriptor it holds. A descriptor ends either when its byte budget is used up or when an end-of-frame marker cuts it short.

At frame boundaries the block writes status back into the host copy of the descriptor: a start flag, or an end flag together with the received byte count. When a descriptor's beat marks a boundary or ends the descriptor, the block also posts a consumed-head writeback and an MSI-X message, if the descriptor asks for them and the global notify enable is on. Every one of these host writes leaves through one in-order write-request port. A consumed head pointer, modulo a power-of-two ring size, is visible for polling. While any write is still owed, the stream sink stays not-ready, so no new boundary can be taken before the previous one has been posted.

Top module: `frame_desc_seq`

## Requirements
- R1: `st_ready` is low whenever no descriptor is held; `desc_ready` is high exactly when no descriptor is held. After reset no descriptor is held and no write is pending.
- R2: The byte counts of accepted beats add up per descriptor, and the descriptor ends when the running total reaches its length. The length field is 21 bits wide and allows up to 1048576 bytes.
- R3: A start update (`wr_kind` 0, address = descriptor address + STAT_OFS, data with only bit 31 set) is issued for an accepted beat that has `st_sof` set. It is also issued for the first beat accepted after reset, or after a descriptor that ended on an end-of-frame marker.
- R4: A beat with `st_eof` ends the descriptor at once. An end update follows (`wr_kind` 1, same address as R3), whose data has bit 30 set, bit 31 set if a start update was issued for this descriptor, and bits 20:0 holding the total bytes received in it.
- R5: After a start update, an end update or a length-based completion, a writeback (`wr_kind` 2, address `wb_addr`, data = head pointer zero-extended, taken after any advance caused by this beat) and then an MSI-X write (`wr_kind` 3, address `msi_addr`, data `msi_data`) are issued. Each is issued at most once per beat, only if the descriptor's own enable bit and `glb_notify_en` are both set.
- R6: With `glb_notify_en` low, start and end updates are still issued, but no writeback and no MSI-X write is issued.
- R7: For one beat the writes leave in the fixed order start update, end update, writeback, MSI-X; a beat with both markers gives two separate update writes.
- R8: `head_ptr` advances by one each time a descriptor ends and wraps modulo 2^RING_AW.
- R9: `st_ready` is low while any write is pending. A write held off by `wr_ready` keeps its kind, address and data unchanged.
- R10: An accepted beat that marks no boundary and does not end its descriptor issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_notify_en | input | 1 | Global enable for writeback and MSI-X writes |
| wb_addr | input | ADDR_W | Host address of the consumed-head writeback |
| msi_addr | input | ADDR_W | MSI-X message address |
| msi_data | input | DATA_W | MSI-X message data |
| desc_valid | input | 1 | A fetched descriptor is offered |
| desc_ready | output | 1 | Descriptor slot is empty |
| desc_addr | input | ADDR_W | Host address of the offered descriptor |
| desc_len | input | LEN_W | Byte budget of the offered descriptor |
| desc_wb_en | input | 1 | Descriptor requests writeback |
| desc_irq_en | input | 1 | Descriptor requests MSI-X |
| st_valid | input | 1 | Stream beat valid |
| st_ready | output | 1 | Stream sink ready |
| st_sof | input | 1 | Beat opens a frame |
| st_eof | input | 1 | Beat closes a frame |
| st_bytes | input | BYTES_W | Valid bytes in the beat (1..BEAT_BYTES) |
| wr_valid | output | 1 | Host write request valid |
| wr_ready | input | 1 | Host write request accepted |
| wr_kind | output | 2 | 0 start update, 1 end update, 2 writeback, 3 MSI-X |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| head_ptr | output | RING_AW | Consumed head pointer |

## Verification
Two events can land on a single beat: a frame boundary that asks for a descriptor update, and the completion of the descriptor, either by an end-of-frame marker or by using up its length. Each brings its own notify writes. The bench provokes this with one-beat frames that carry both markers, with start beats that also use up the budget, and with end beats that arrive exactly as the byte total reaches the length. It judges the result by comparing the exact sequence of writes against a scoreboard, while `wr_ready` is throttled so that every write also has to hold steady under backpressure.

// File: rtl/fdu_pkg.sv
// Shared types for the frame descriptor update sequencer.
// Assumes: the write kind encoding is visible to host-side decoders.
package fdu_pkg;

    // Kind of host write; the numeric codes are part of the port contract.
    typedef enum logic [1:0] {
        WK_SOF = 2'd0,
        WK_EOF = 2'd1,
        WK_WB  = 2'd2,
        WK_MSI = 2'd3
    } wr_kind_e;

    // Set of writes still owed for one accepted beat.
    typedef struct packed {
        logic sof;
        logic eof;
        logic wb;
        logic msi;
    } op_set_t;

    // Highest-priority owed write, in the fixed issue order.
    function automatic wr_kind_e first_op(input op_set_t ops);
        if (ops.sof)      return WK_SOF;
        else if (ops.eof) return WK_EOF;
        else if (ops.wb)  return WK_WB;
        else              return WK_MSI;
    endfunction

    // Remove one write kind from an owed set.
    function automatic op_set_t drop_op(input op_set_t ops, input wr_kind_e k);
        op_set_t r;
        r = ops;
        case (k)
            WK_SOF:  r.sof = 1'b0;
            WK_EOF:  r.eof = 1'b0;
            WK_WB:   r.wb  = 1'b0;
            default: r.msi = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fdu_desc_slot.sv
// One-deep holding register for the active receive descriptor.
// Loads an offered descriptor when empty and empties on release.
// Assumes: release is only raised while a descriptor is held.
module fdu_desc_slot #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_wb,
    input  logic              in_irq,
    input  logic              release_i,
    output logic              held,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_len,
    output logic              cur_wb,
    output logic              cur_irq
);

    logic              held_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              wb_q;
    logic              irq_q;

    // Occupancy: set on load, cleared when the descriptor ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (release_i) begin
            held_q <= 1'b0;
        end else if (in_valid && !held_q) begin
            held_q <= 1'b1;
        end
    end

    // Descriptor fields captured on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            wb_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else if (in_valid && !held_q) begin
            addr_q <= in_addr;
            len_q  <= in_len;
            wb_q   <= in_wb;
            irq_q  <= in_irq;
        end
    end

    // Slot outputs.
    always_comb begin
        in_ready = !held_q;
        held     = held_q;
        cur_addr = addr_q;
        cur_len  = len_q;
        cur_wb   = wb_q;
        cur_irq  = irq_q;
    end

endmodule

// File: rtl/fdu_frame_track.sv
// Per-descriptor byte counter and frame boundary tracker.
// For each accepted beat it reports whether the beat opens a frame,
// closes one, ends the descriptor, and the running byte total.
// Assumes: beat_bytes is nonzero; cur_len is nonzero.
module fdu_frame_track #(
    parameter int LEN_W   = 21,
    parameter int BYTES_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_fire,
    input  logic               beat_sof,
    input  logic               beat_eof,
    input  logic [BYTES_W-1:0] beat_bytes,
    input  logic [LEN_W-1:0]   cur_len,
    output logic               ev_start,
    output logic               ev_eof,
    output logic               ev_done,
    output logic               ev_dsof,
    output logic [LEN_W-1:0]   ev_count
);

    logic [LEN_W-1:0] cnt_q;
    logic             dsof_q;
    logic             after_eof_q;
    logic [LEN_W-1:0] sum;

    // Beat classification against the held descriptor.
    always_comb begin
        sum      = cnt_q + LEN_W'(beat_bytes);
        ev_start = beat_sof || after_eof_q;
        ev_eof   = beat_eof;
        ev_done  = beat_eof || (sum >= cur_len);
        ev_dsof  = dsof_q || ev_start;
        ev_count = sum;
    end

    // Running count and start-seen flag, cleared when the descriptor ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dsof_q <= 1'b0;
        end else if (beat_fire) begin
            if (ev_done) begin
                cnt_q  <= '0;
                dsof_q <= 1'b0;
            end else begin
                cnt_q  <= sum;
                dsof_q <= ev_dsof;
            end
        end
    end

    // Marks that the next accepted beat begins a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_eof_q <= 1'b1;
        end else if (beat_fire) begin
            after_eof_q <= ev_done && beat_eof;
        end
    end

endmodule

// File: rtl/fdu_head_ptr.sv
// Consumed head pointer over a power-of-two ring.
// Assumes: ring size is 2**RING_AW, so wrap is plain overflow.
module fdu_head_ptr #(
    parameter int RING_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [RING_AW-1:0] ptr
);

    logic [RING_AW-1:0] ptr_q;

    // Step by one per completed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Drive the pointer out.
    always_comb ptr = ptr_q;

endmodule

// File: rtl/fdu_wr_sched.sv
// Ordered issuer of host writes owed for one accepted beat.
// Captures the owed set and a snapshot of the descriptor fields at the
// beat, then emits start update, end update, writeback and MSI-X in
// that order over one valid/ready port.
// Assumes: capture is never raised while busy is high.
module fdu_wr_sched
    import fdu_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 21,
    parameter int RING_AW  = 4,
    parameter int STAT_OFS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               ev_start,
    input  logic               ev_eof,
    input  logic               ev_done,
    input  logic               ev_dsof,
    input  logic [LEN_W-1:0]   ev_count,
    input  logic [ADDR_W-1:0]  d_addr,
    input  logic               d_wb,
    input  logic               d_irq,
    input  logic               glb_en,
    input  logic [ADDR_W-1:0]  wb_addr,
    input  logic [ADDR_W-1:0]  msi_addr,
    input  logic [DATA_W-1:0]  msi_data,
    input  logic [RING_AW-1:0] head,
    output logic               busy,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [1:0]         wr_kind,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data
);

    localparam int PAD_W = DATA_W - 2 - LEN_W;

    op_set_t           pend_q;
    op_set_t           capt_set;
    logic [ADDR_W-1:0] stat_addr_q;
    logic [DATA_W-1:0] eof_data_q;
    wr_kind_e          cur_k;
    logic              notify;

    // Writes owed for the beat being captured.
    always_comb begin
        notify       = ev_start || ev_done;
        capt_set.sof = ev_start;
        capt_set.eof = ev_eof;
        capt_set.wb  = notify && glb_en && d_wb;
        capt_set.msi = notify && glb_en && d_irq;
    end

    // Owed set: loaded at the beat, one kind removed per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (capture) begin
            pend_q <= capt_set;
        end else if (wr_valid && wr_ready) begin
            pend_q <= drop_op(pend_q, cur_k);
        end
    end

    // Snapshot of descriptor status address and end-update word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_addr_q <= '0;
            eof_data_q  <= '0;
        end else if (capture) begin
            stat_addr_q <= d_addr + ADDR_W'(STAT_OFS);
            eof_data_q  <= {ev_dsof, 1'b1, {PAD_W{1'b0}}, ev_count};
        end
    end

    // Present the highest-priority owed write.
    always_comb begin
        busy     = |pend_q;
        wr_valid = busy;
        cur_k    = first_op(pend_q);
        wr_kind  = cur_k;
        case (cur_k)
            WK_SOF: begin
                wr_addr = stat_addr_q;
                wr_data = {1'b1, {(DATA_W-1){1'b0}}};
            end
            WK_EOF: begin
                wr_addr = stat_addr_q;
                wr_data = eof_data_q;
            end
            WK_WB: begin
                wr_addr = wb_addr;
                wr_data = DATA_W'(head);
            end
            default: begin
                wr_addr = msi_addr;
                wr_data = msi_data;
            end
        endcase
    end

endmodule

// File: rtl/frame_desc_seq.sv
// Stream frame descriptor update sequencer, top level.
// Joins the descriptor slot, the frame tracker, the head pointer and
// the ordered write scheduler. The sink takes a beat only when a
// descriptor is held and no write is owed.
// Assumes: st_bytes is 1..BEAT_BYTES; descriptor lengths are nonzero.
module frame_desc_seq #(
    parameter int ADDR_W     = 64,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 21,
    parameter int BEAT_BYTES = 32,
    parameter int RING_AW    = 4,
    parameter int STAT_OFS   = 12,
    localparam int BYTES_W   = $clog2(BEAT_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_notify_en,
    input  logic [ADDR_W-1:0]  wb_addr,
    input  logic [ADDR_W-1:0]  msi_addr,
    input  logic [DATA_W-1:0]  msi_data,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [ADDR_W-1:0]  desc_addr,
    input  logic [LEN_W-1:0]   desc_len,
    input  logic               desc_wb_en,
    input  logic               desc_irq_en,
    input  logic               st_valid,
    output logic               st_ready,
    input  logic               st_sof,
    input  logic               st_eof,
    input  logic [BYTES_W-1:0] st_bytes,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [1:0]         wr_kind,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [RING_AW-1:0] head_ptr
);

    logic              held;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;
    logic              cur_wb;
    logic              cur_irq;
    logic              busy;
    logic              fire;
    logic              ev_start;
    logic              ev_eof;
    logic              ev_done;
    logic              ev_dsof;
    logic [LEN_W-1:0]  ev_count;

    // Sink handshake: a beat needs a held descriptor and an idle write port.
    always_comb begin
        st_ready = held && !busy;
        fire     = st_valid && st_ready;
    end

    fdu_desc_slot #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (desc_valid),
        .in_ready  (desc_ready),
        .in_addr   (desc_addr),
        .in_len    (desc_len),
        .in_wb     (desc_wb_en),
        .in_irq    (desc_irq_en),
        .release_i (fire && ev_done),
        .held      (held),
        .cur_addr  (cur_addr),
        .cur_len   (cur_len),
        .cur_wb    (cur_wb),
        .cur_irq   (cur_irq)
    );

    fdu_frame_track #(
        .LEN_W   (LEN_W),
        .BYTES_W (BYTES_W)
    ) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_fire  (fire),
        .beat_sof   (st_sof),
        .beat_eof   (st_eof),
        .beat_bytes (st_bytes),
        .cur_len    (cur_len),
        .ev_start   (ev_start),
        .ev_eof     (ev_eof),
        .ev_done    (ev_done),
        .ev_dsof    (ev_dsof),
        .ev_count   (ev_count)
    );

    fdu_head_ptr #(
        .RING_AW (RING_AW)
    ) head_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fire && ev_done),
        .ptr     (head_ptr)
    );

    fdu_wr_sched #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LEN_W    (LEN_W),
        .RING_AW  (RING_AW),
        .STAT_OFS (STAT_OFS)
    ) sched_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (fire),
        .ev_start (ev_start),
        .ev_eof   (ev_eof),
        .ev_done  (ev_done),
        .ev_dsof  (ev_dsof),
        .ev_count (ev_count),
        .d_addr   (cur_addr),
        .d_wb     (cur_wb),
        .d_irq    (cur_irq),
        .glb_en   (glb_notify_en),
        .wb_addr  (wb_addr),
        .msi_addr (msi_addr),
        .msi_data (msi_data),
        .head     (head_ptr),
        .busy     (busy),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_kind  (wr_kind),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/frame_desc_seq_chk.sv
// Port-level protocol checks for frame_desc_seq, attached by bind.
// Assumes: reset is held low for at least one clock at start.
module frame_desc_seq_chk #(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    parameter int RING_AW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_valid,
    input logic               st_ready,
    input logic               st_sof,
    input logic               st_eof,
    input logic               desc_ready,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [1:0]         wr_kind,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [RING_AW-1:0] head_ptr
);

    // R1: the sink never offers room without a held descriptor.
    a_r1_ready_needs_desc: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> !desc_ready);

    // R9: no beat is taken while a write is owed.
    a_r9_no_beat_while_owed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !st_ready);

    // R9: a stalled write holds its fields.
    a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_kind)
                                     && $stable(wr_addr) && $stable(wr_data)));

    // R3: a start-marked beat is followed by a start update first.
    a_r3_sof_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_sof) |=> (wr_valid && wr_kind == 2'd0));

    // R4: an end-marked beat without start marker leads with an update write.
    a_r4_eof_update: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_eof && !st_sof)
            |=> (wr_valid && (wr_kind == 2'd0 || wr_kind == 2'd1)));

    // R8: the head pointer only ever steps by one (modulo ring size).
    a_r8_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_ptr) |-> (head_ptr == $past(head_ptr) + 1'b1));

endmodule

bind frame_desc_seq frame_desc_seq_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RING_AW (RING_AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_sof     (st_sof),
    .st_eof     (st_eof),
    .desc_ready (desc_ready),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_kind    (wr_kind),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .head_ptr   (head_ptr)
);

// File: tb/frame_desc_seq_tb_top.sv
// Scoreboard bench for frame_desc_seq: the beat driver predicts the
// host writes, a monitor compares them as they are accepted.
module frame_desc_seq_tb_top;

    localparam int ADDR_W = 64;
    localparam int DATA_W = 32;
    localparam int LEN_W = 21;
    localparam int BEAT_BYTES = 32;
    localparam int RING_AW = 4;
    localparam int STAT_OFS = 12;
    localparam int BYTES_W = $clog2(BEAT_BYTES + 1);
    localparam logic [ADDR_W-1:0] WB_A = 64'h0000_00F0_0000_0100;
    localparam logic [ADDR_W-1:0] MSI_A = 64'h0000_00FE_E000_0040;
    localparam logic [DATA_W-1:0] MSI_D = 32'h0000_4A21;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               glb_notify_en = 1'b1;
    logic               desc_valid = 1'b0;
    logic               desc_ready;
    logic [ADDR_W-1:0]  desc_addr = '0;
    logic [LEN_W-1:0]   desc_len = '0;
    logic               desc_wb_en = 1'b0;
    logic               desc_irq_en = 1'b0;
    logic               st_valid = 1'b0;
    logic               st_ready;
    logic               st_sof = 1'b0;
    logic               st_eof = 1'b0;
    logic [BYTES_W-1:0] st_bytes = '0;
    logic               wr_valid;
    logic               wr_ready = 1'b0;
    logic [1:0]         wr_kind;
    logic [ADDR_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  wr_data;
    logic [RING_AW-1:0] head_ptr;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [LEN_W-1:0]  len;
        logic              wb;
        logic              irq;
    } desc_t;

    typedef struct {
        logic [1:0]        k;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } wr_t;

    desc_t feedq[$];
    desc_t mq[$];
    wr_t   expq[$];
    string tagq[$];

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    // Bench model state.
    logic [LEN_W-1:0]   m_cnt = '0;
    bit                 m_dsof = 1'b0;
    bit                 m_after_eof = 1'b1;
    logic [RING_AW-1:0] m_head = '0;

    always #2 clk = ~clk;

    frame_desc_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .BEAT_BYTES(BEAT_BYTES), .RING_AW(RING_AW), .STAT_OFS(STAT_OFS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .glb_notify_en(glb_notify_en),
        .wb_addr(WB_A), .msi_addr(MSI_A), .msi_data(MSI_D),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_len(desc_len),
        .desc_wb_en(desc_wb_en), .desc_irq_en(desc_irq_en),
        .st_valid(st_valid), .st_ready(st_ready), .st_sof(st_sof),
        .st_eof(st_eof), .st_bytes(st_bytes),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data), .head_ptr(head_ptr)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input string tag);
        wr_t w;
        w.k = k; w.a = a; w.d = d;
        expq.push_back(w);
        tagq.push_back(tag);
    endtask

    task automatic push_desc(input logic [ADDR_W-1:0] a, input int len,
                             input bit wb, input bit irq);
        desc_t d;
        d.a = a; d.len = LEN_W'(len); d.wb = wb; d.irq = irq;
        feedq.push_back(d);
        mq.push_back(d);
    endtask

    // Descriptor feeder: pops an entry once its handshake edge has passed.
    bit hs_pend = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hs_pend = 1'b0;
            desc_valid = 1'b0;
        end else begin
            if (hs_pend) void'(feedq.pop_front());
            if (feedq.size() > 0) begin
                desc_valid = 1'b1;
                desc_addr = feedq[0].a;
                desc_len = feedq[0].len;
                desc_wb_en = feedq[0].wb;
                desc_irq_en = feedq[0].irq;
            end else begin
                desc_valid = 1'b0;
            end
            hs_pend = desc_valid && desc_ready;
        end
    end

    // Write monitor with throttled ready; compares against the scoreboard.
    always @(negedge clk) begin
        cyc++;
        wr_ready = (cyc % 3) != 1;
        if (rst_n && wr_valid && wr_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R10 unexpected write", {62'd0, wr_kind}, 64'd0);
            end else begin
                wr_t w;
                string t;
                w = expq.pop_front();
                t = tagq.pop_front();
                check(wr_kind == w.k, {t, " kind"}, {62'd0, wr_kind}, {62'd0, w.k});
                check(wr_addr == w.a, {t, " addr"}, wr_addr, w.a);
                check(wr_data == w.d, {t, " data"}, {32'd0, wr_data}, {32'd0, w.d});
            end
        end
    end

    // Offer one beat, predict its writes at the accepting edge.
    task automatic send_beat(input bit sof, input bit eof, input int nbytes);
        bit start, done, notify, any;
        desc_t d;
        logic [LEN_W-1:0] sum;
        st_valid = 1'b1; st_sof = sof; st_eof = eof; st_bytes = BYTES_W'(nbytes);
        while (!st_ready) @(negedge clk);
        d = mq[0];
        sum = m_cnt + LEN_W'(nbytes);
        start = sof || m_after_eof;
        done = eof || (sum >= d.len);
        notify = start || done;
        any = start || eof || (notify && glb_notify_en && (d.wb || d.irq));
        if (start) m_dsof = 1'b1;
        if (done) m_head = m_head + 1'b1;
        if (start) expect_wr(2'd0, d.a + STAT_OFS, 32'h8000_0000, "R3 start update");
        if (eof) expect_wr(2'd1, d.a + STAT_OFS,
                           {m_dsof, 1'b1, 9'd0, sum}, "R4 end update");
        if (notify && glb_notify_en && d.wb)
            expect_wr(2'd2, WB_A, DATA_W'(m_head), "R5 writeback");
        if (notify && glb_notify_en && d.irq)
            expect_wr(2'd3, MSI_A, MSI_D, "R5 msix");
        if (done) begin
            void'(mq.pop_front());
            m_cnt = '0; m_dsof = 1'b0; m_after_eof = eof;
        end else begin
            m_cnt = sum; m_after_eof = 1'b0;
        end
        @(negedge clk);
        st_valid = 1'b0; st_sof = 1'b0; st_eof = 1'b0;
        if (any) check(!st_ready, "R9 ready low while owed", {63'd0, st_ready}, 64'd0);
        else check(!wr_valid, "R10 no write for plain beat", {63'd0, wr_valid}, 64'd0);
    endtask

    task automatic drain();
        int n = 0;
        while ((expq.size() > 0 || wr_valid) && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(st_ready == 1'b0, "R1 reset st_ready", {63'd0, st_ready}, 64'd0);
        check(desc_ready == 1'b1, "R1 reset desc_ready", {63'd0, desc_ready}, 64'd1);
        check(wr_valid == 1'b0, "R1 reset wr_valid", {63'd0, wr_valid}, 64'd0);
        check(head_ptr == 0, "R8 reset head", {60'd0, head_ptr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: beat offered with no descriptor is refused
        st_valid = 1'b1; st_sof = 1'b1; st_bytes = 6'd8;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(st_ready == 1'b0, "R1 no descriptor", {63'd0, st_ready}, 64'd0);
        end
        st_valid = 1'b0; st_sof = 1'b0;

        // R3 R4 R5: frame cut short by end marker, full notify
        push_desc(64'h1000, 96, 1'b1, 1'b1);
        send_beat(1'b1, 1'b0, 32);
        send_beat(1'b0, 1'b0, 32);
        send_beat(1'b0, 1'b1, 16);
        drain();

        // R2 R10: frame spanning descriptors, completion by length
        push_desc(64'h2000, 64, 1'b1, 1'b0);
        push_desc(64'h3000, 64, 1'b0, 1'b1);
        send_beat(1'b1, 1'b0, 32);
        send_beat(1'b0, 1'b0, 32);
        send_beat(1'b0, 1'b0, 32);
        send_beat(1'b0, 1'b1, 16);
        drain();

        // R6 R7: single-beat frame with global notify off
        glb_notify_en = 1'b0;
        push_desc(64'h4000, 64, 1'b1, 1'b1);
        send_beat(1'b1, 1'b1, 8);
        drain();
        glb_notify_en = 1'b1;

        // R7: single-beat frame using full budget, notify on
        push_desc(64'h5000, 32, 1'b1, 1'b1);
        send_beat(1'b1, 1'b1, 32);
        drain();

        // R3: descriptor after an end marker gets a start update unasked
        push_desc(64'h6000, 64, 1'b0, 1'b0);
        send_beat(1'b0, 1'b0, 32);
        send_beat(1'b0, 1'b1, 32);
        drain();

        // R2: maximum 1 MB descriptor completes exactly at its length
        push_desc(64'h7000, 1 << 20, 1'b1, 1'b0);
        send_beat(1'b1, 1'b0, 32);
        for (int i = 1; i < (1 << 20) / 32; i++) send_beat(1'b0, 1'b0, 32);
        drain();
        check(head_ptr == 4'd7, "R2 head after 1MB", {60'd0, head_ptr}, 64'd7);

        // R8: head wraps modulo ring size
        for (int i = 0; i < 12; i++) push_desc(64'h9000 + 64'(i * 64), 32, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) send_beat(1'b0, 1'b0, 32);
        drain();
        check(head_ptr == m_head, "R8 head wrap", {60'd0, head_ptr}, {60'd0, m_head});
        check(head_ptr == 4'd3, "R8 head wrap value", {60'd0, head_ptr}, 64'd3);

        check(expq.size() == 0, "R7 all expected writes seen", 64'(expq.size()), 64'd0);
        finish_run();
    end

endmodule